// File: doc/BRIEF.md
# Coherent Cache Line State Controller

This block tracks a four-valued coherence state for every line of a small write-back cache. Each cycle it takes at most one event: a local request from the core side, a fill completing from the bus, or a snooped request from another agent. It updates the addressed line's state and reports, in the same cycle, whether a local access hits and which bus action the surrounding logic has to perform. Data storage and bus arbitration belong to the neighbouring logic.

A line that is the system's only clean copy can be written with no bus traffic. A line that other caches may also hold must first claim ownership on the bus. A dirty line is written back when a local clean or evict asks for it, or when a snooper wants the line. When a read fill completes, the shared response from the bus decides whether the line becomes sole-clean or shared.

Top module: `mesi_line_ctrl`

## Requirements
- R1: The line state is two bits: Invalid=00, Shared=01, Exclusive=10, Modified=11. Reset sets every line to Invalid, and `probe_state` returns the state of line `probe_idx`.
- R2: A local read (op=001) of a valid line gives hit=1 and bus_act=00 (none). A local read of an Invalid line gives hit=0 and bus_act=01 (read), and leaves the line Invalid.
- R3: A fill sets its line to Modified when `fill_own`=1. Otherwise it sets the line to Shared when `fill_shared`=1 and to Exclusive when `fill_shared`=0.
- R4: A local write (op=010) to an Exclusive line gives hit=1 and bus_act=00, and the line becomes Modified.
- R5: A local write to a Shared line gives hit=1 and bus_act=10 (read-for-ownership), and the line becomes Modified. A local write to an Invalid line gives hit=0 and bus_act=10, and leaves the line Invalid.
- R6: A local clean (op=011) of a Modified line gives bus_act=11 (writeback), and the line becomes Exclusive. A clean of any other state gives bus_act=00 and changes nothing.
- R7: A local evict (op=100) makes the line Invalid. It gives bus_act=11 when the line was Modified and 00 otherwise.
- R8: A snooped read (snp_rfo=0) turns Modified into Shared with bus_act=11, and turns Exclusive into Shared with bus_act=00. It leaves Shared and Invalid lines unchanged.
- R9: A snooped read-for-ownership (snp_rfo=1) makes the line Invalid. It gives bus_act=11 when the line was Modified and 00 otherwise.
- R10: Events are taken in the order snoop, then fill, then local. An event of lower priority in the same cycle is dropped: a dropped local request gives hit=0 and leaves its line unchanged.
- R11: `bus_idx` equals `snp_idx` while a snoop is present, and `op_idx` otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Local op: 000 none, 001 read, 010 write, 011 clean, 100 evict |
| op_idx | input | IDX_W | Line addressed by the local op |
| snp_valid | input | 1 | Snooped request present |
| snp_rfo | input | 1 | Snoop kind: 1 read-for-ownership, 0 read |
| snp_idx | input | IDX_W | Line addressed by the snoop |
| fill_valid | input | 1 | Fill completes this cycle |
| fill_own | input | 1 | Fill was requested for ownership |
| fill_shared | input | 1 | Shared response seen during the fill |
| fill_idx | input | IDX_W | Line being filled |
| probe_idx | input | IDX_W | Line whose state is shown on probe_state |
| hit | output | 1 | Local read or write found a usable line |
| bus_act | output | 2 | Required bus action: 00 none, 01 read, 10 read-for-ownership, 11 writeback |
| bus_idx | output | IDX_W | Line the bus action refers to |
| probe_state | output | 2 | State of line probe_idx |

## Verification
The hardest situation to reach is a collision: a snoop or a fill arriving in the same cycle as a local write to a line that would otherwise silently become Modified. The bench first drives a line to Exclusive or Shared with a fill. It then presents the colliding events in a single cycle and checks that the local request reports no hit and that the line ends in the state the winning event gives, not Modified. Each state is also walked in turn through clean, evict and both snoop kinds, so that every writeback path is triggered from a Modified line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_st_t;

    typedef enum logic [1:0] {
        BUS_NONE = 2'b00,
        BUS_RD   = 2'b01,
        BUS_RFO  = 2'b10,
        BUS_WB   = 2'b11
    } bus_op_t;

    typedef enum logic [2:0] {
        OP_NOP   = 3'b000,
        OP_RD    = 3'b001,
        OP_WR    = 3'b010,
        OP_CLEAN = 3'b011,
        OP_EVICT = 3'b100
    } loc_op_t;

    typedef struct packed {
        logic     upd;
        line_st_t nxt;
        bus_op_t  act;
        logic     hit;
    } decision_t;

    function automatic line_st_t fill_state(logic own, logic shared);
        if (own)
            return ST_M;
        else if (shared)
            return ST_S;
        else
            return ST_E;
    endfunction

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array #(
    parameter int LINES = 8,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDX_W-1:0]     widx,
    input  logic [1:0]           wst,
    output logic [2*LINES-1:0]   st_all
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [1:0] st_q;
        always_ff @(posedge clk) begin
            if (rst)
                st_q <= mesi_pkg::ST_I;
            else if (we && (widx == IDX_W'(g)))
                st_q <= wst;
        end
        assign st_all[2*g +: 2] = st_q;
    end
endmodule

// File: rtl/mesi_local_dec.sv
module mesi_local_dec
    import mesi_pkg::*;
(
    input  loc_op_t   op,
    input  line_st_t  st,
    output decision_t dec
);
    always_comb begin
        dec = '{upd: 1'b0, nxt: st, act: BUS_NONE, hit: 1'b0};
        unique case (op)
            OP_RD: begin
                if (st == ST_I)
                    dec.act = BUS_RD;
                else
                    dec.hit = 1'b1;
            end
            OP_WR: begin
                unique case (st)
                    ST_M: dec.hit = 1'b1;
                    ST_E: begin
                        dec.hit = 1'b1;
                        dec.upd = 1'b1;
                        dec.nxt = ST_M;
                    end
                    ST_S: begin
                        dec.hit = 1'b1;
                        dec.act = BUS_RFO;
                        dec.upd = 1'b1;
                        dec.nxt = ST_M;
                    end
                    default: dec.act = BUS_RFO;
                endcase
            end
            OP_CLEAN: begin
                if (st == ST_M) begin
                    dec.act = BUS_WB;
                    dec.upd = 1'b1;
                    dec.nxt = ST_E;
                end
            end
            OP_EVICT: begin
                dec.upd = 1'b1;
                dec.nxt = ST_I;
                if (st == ST_M)
                    dec.act = BUS_WB;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mesi_snoop_dec.sv
module mesi_snoop_dec
    import mesi_pkg::*;
(
    input  logic      rfo,
    input  line_st_t  st,
    output decision_t dec
);
    always_comb begin
        dec = '{upd: 1'b0, nxt: st, act: BUS_NONE, hit: 1'b0};
        if (st == ST_M)
            dec.act = BUS_WB;
        if (rfo) begin
            dec.upd = 1'b1;
            dec.nxt = ST_I;
        end else if (st == ST_M || st == ST_E) begin
            dec.upd = 1'b1;
            dec.nxt = ST_S;
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int LINES = 8,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op,
    input  logic [IDX_W-1:0] op_idx,
    input  logic             snp_valid,
    input  logic             snp_rfo,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic             fill_valid,
    input  logic             fill_own,
    input  logic             fill_shared,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             hit,
    output logic [1:0]       bus_act,
    output logic [IDX_W-1:0] bus_idx,
    output logic [1:0]       probe_state
);
    logic [2*LINES-1:0] st_all;
    logic               we;
    logic [IDX_W-1:0]   widx;
    logic [1:0]         wst;
    line_st_t           st_op;
    line_st_t           st_snp;
    decision_t          ld;
    decision_t          sd;

    assign st_op       = line_st_t'(st_all[{op_idx, 1'b0} +: 2]);
    assign st_snp      = line_st_t'(st_all[{snp_idx, 1'b0} +: 2]);
    assign probe_state = st_all[{probe_idx, 1'b0} +: 2];

    mesi_local_dec u_ldec (
        .op  (loc_op_t'(op)),
        .st  (st_op),
        .dec (ld)
    );

    mesi_snoop_dec u_sdec (
        .rfo (snp_rfo),
        .st  (st_snp),
        .dec (sd)
    );

    always_comb begin
        we      = 1'b0;
        widx    = op_idx;
        wst     = ST_I;
        hit     = 1'b0;
        bus_act = BUS_NONE;
        bus_idx = op_idx;
        if (snp_valid) begin
            we      = sd.upd;
            widx    = snp_idx;
            wst     = sd.nxt;
            bus_act = sd.act;
            bus_idx = snp_idx;
        end else if (fill_valid) begin
            we   = 1'b1;
            widx = fill_idx;
            wst  = fill_state(fill_own, fill_shared);
        end else begin
            we      = ld.upd;
            wst     = ld.nxt;
            hit     = ld.hit;
            bus_act = ld.act;
        end
    end

    mesi_state_array #(.LINES(LINES), .IDX_W(IDX_W)) u_arr (
        .clk    (clk),
        .rst    (rst),
        .we     (we),
        .widx   (widx),
        .wst    (wst),
        .st_all (st_all)
    );
endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk #(
    parameter int LINES = 8,
    parameter int IDX_W = $clog2(LINES)
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         op,
    input logic [IDX_W-1:0]   op_idx,
    input logic               snp_valid,
    input logic               snp_rfo,
    input logic [IDX_W-1:0]   snp_idx,
    input logic               fill_valid,
    input logic               hit,
    input logic [1:0]         bus_act,
    input logic [IDX_W-1:0]   bus_idx,
    input logic [1:0]         probe_state,
    input logic [2*LINES-1:0] st_all
);
    function automatic logic [1:0] st_at(logic [IDX_W-1:0] i);
        return st_all[{i, 1'b0} +: 2];
    endfunction

    logic local_only;
    assign local_only = !snp_valid && !fill_valid;

    // R1: every line reads Invalid in the cycle after reset
    a_r1_reset_invalid: assert property (@(posedge clk)
        $past(rst) |-> probe_state == 2'b00);

    // R4: write to a sole clean copy needs no bus and turns Modified
    a_r4_silent_upgrade: assert property (@(posedge clk) disable iff (rst)
        (local_only && op == 3'b010 && st_at(op_idx) == 2'b10)
        |-> (hit && bus_act == 2'b00) ##1 st_at($past(op_idx)) == 2'b11);

    // R7: evict leaves the line Invalid
    a_r7_evict_invalid: assert property (@(posedge clk) disable iff (rst)
        (local_only && op == 3'b100) |=> st_at($past(op_idx)) == 2'b00);

    // R8/R9: a snooped Modified line is always written back
    a_r8_snoop_dirty_wb: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && st_at(snp_idx) == 2'b11) |-> bus_act == 2'b11);

    // R9: snooped read-for-ownership invalidates
    a_r9_rfo_invalidates: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_rfo) |=> st_at($past(snp_idx)) == 2'b00);

    // R10: no local hit while a snoop or fill takes the cycle
    a_r10_local_dropped: assert property (@(posedge clk) disable iff (rst)
        (snp_valid || fill_valid) |-> !hit);

    // R11: bus index follows the snoop
    a_r11_bus_idx: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> bus_idx == snp_idx);
endmodule

bind mesi_line_ctrl mesi_line_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .op_idx      (op_idx),
    .snp_valid   (snp_valid),
    .snp_rfo     (snp_rfo),
    .snp_idx     (snp_idx),
    .fill_valid  (fill_valid),
    .hit         (hit),
    .bus_act     (bus_act),
    .bus_idx     (bus_idx),
    .probe_state (probe_state),
    .st_all      (st_all)
);

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
    localparam int LINES = 8;
    localparam int IW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op = '0;
    logic [IW-1:0] op_idx = '0;
    logic          snp_valid = 1'b0;
    logic          snp_rfo = 1'b0;
    logic [IW-1:0] snp_idx = '0;
    logic          fill_valid = 1'b0;
    logic          fill_own = 1'b0;
    logic          fill_shared = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic [IW-1:0] probe_idx = '0;
    logic          hit;
    logic [1:0]    bus_act;
    logic [IW-1:0] bus_idx;
    logic [1:0]    probe_state;

    int checks = 0;
    int fails  = 0;
    logic          c_hit;
    logic [1:0]    c_act;
    logic [IW-1:0] c_idx;

    always #5 clk = ~clk;

    mesi_line_ctrl #(.LINES(LINES)) u0 (.*);

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // present one cycle of stimulus; capture outputs before the edge
    task automatic cyc(input logic [2:0] o, input int oi,
                       input logic sv, input logic sr, input int si,
                       input logic fv, input logic fo, input logic fs, input int fi);
        op = o; op_idx = IW'(oi);
        snp_valid = sv; snp_rfo = sr; snp_idx = IW'(si);
        fill_valid = fv; fill_own = fo; fill_shared = fs; fill_idx = IW'(fi);
        #1;
        c_hit = hit; c_act = bus_act; c_idx = bus_idx;
        @(negedge clk);
        op = '0; snp_valid = 1'b0; fill_valid = 1'b0;
    endtask

    task automatic probe(input int i, output int s);
        probe_idx = IW'(i);
        #1;
        s = int'(probe_state);
    endtask

    task automatic lop(input logic [2:0] o, input int i);
        cyc(o, i, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(input int i, input logic own, input logic sh);
        cyc(3'b000, 0, 0, 0, 0, 1, own, sh, i);
    endtask

    task automatic snoop(input int i, input logic rfo);
        cyc(3'b000, 0, 1, rfo, i, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        int s;
        for (int i = 0; i < LINES; i++) begin
            probe(i, s);
            check("R1 reset state", s, 0);
        end
    endtask

    task automatic t_read_fill();
        int s;
        lop(3'b001, 3);
        check("R2 read miss hit", c_hit, 0);
        check("R2 read miss act", c_act, 1);
        check("R11 bus idx local", c_idx, 3);
        probe(3, s); check("R2 miss keeps I", s, 0);
        fill(3, 0, 0);
        probe(3, s); check("R3 fill alone E", s, 2);
        lop(3'b001, 3);
        check("R2 read hit", c_hit, 1);
        check("R2 read hit act", c_act, 0);
        fill(4, 0, 1);
        probe(4, s); check("R3 fill shared S", s, 1);
        fill(5, 1, 1);
        probe(5, s); check("R3 fill own M", s, 3);
    endtask

    task automatic t_write();
        int s;
        lop(3'b010, 3);
        check("R4 write E hit", c_hit, 1);
        check("R4 write E act", c_act, 0);
        probe(3, s); check("R4 E to M", s, 3);
        lop(3'b010, 4);
        check("R5 write S hit", c_hit, 1);
        check("R5 write S act", c_act, 2);
        probe(4, s); check("R5 S to M", s, 3);
        lop(3'b010, 6);
        check("R5 write I hit", c_hit, 0);
        check("R5 write I act", c_act, 2);
        probe(6, s); check("R5 I stays I", s, 0);
    endtask

    task automatic t_clean();
        int s;
        lop(3'b011, 3);
        check("R6 clean M act", c_act, 3);
        probe(3, s); check("R6 M to E", s, 2);
        lop(3'b011, 3);
        check("R6 clean E act", c_act, 0);
        probe(3, s); check("R6 E unchanged", s, 2);
    endtask

    task automatic t_evict();
        int s;
        fill(1, 0, 1);
        lop(3'b100, 1);
        check("R7 evict S act", c_act, 0);
        probe(1, s); check("R7 S to I", s, 0);
        lop(3'b100, 5);
        check("R7 evict M act", c_act, 3);
        probe(5, s); check("R7 M to I", s, 0);
    endtask

    task automatic t_snoop();
        int s;
        snoop(3, 0);
        check("R8 snoop rd E act", c_act, 0);
        probe(3, s); check("R8 E to S", s, 1);
        snoop(4, 0);
        check("R8 snoop rd M act", c_act, 3);
        check("R11 bus idx snoop", c_idx, 4);
        probe(4, s); check("R8 M to S", s, 1);
        snoop(0, 0);
        check("R8 snoop rd I act", c_act, 0);
        probe(0, s); check("R8 I unchanged", s, 0);
        snoop(3, 1);
        check("R9 rfo S act", c_act, 0);
        probe(3, s); check("R9 S to I", s, 0);
        fill(2, 1, 0);
        snoop(2, 1);
        check("R9 rfo M act", c_act, 3);
        probe(2, s); check("R9 M to I", s, 0);
    endtask

    task automatic t_priority();
        int s;
        fill(7, 0, 0);
        cyc(3'b010, 7, 1, 0, 7, 0, 0, 0, 0);
        check("R10 snoop beats local hit", c_hit, 0);
        check("R11 bus idx on collision", c_idx, 7);
        probe(7, s); check("R10 snoop wins S", s, 1);
        cyc(3'b010, 4, 0, 0, 0, 1, 0, 0, 0);
        check("R10 fill beats local hit", c_hit, 0);
        check("R10 fill beats local act", c_act, 0);
        probe(0, s); check("R10 fill applied", s, 2);
        probe(4, s); check("R10 local dropped", s, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_fill();
        t_write();
        t_clean();
        t_evict();
        t_snoop();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule